// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This combinational unit sits between a pipeline's memory stage and a 32-bit data memory port. On a store it turns the access size, the low two address bits and the source register value into a per-byte write mask and a write word whose narrow value is copied into every byte lane. The memory then picks the lanes it needs through the mask.

On a load it takes the raw word read from memory and moves the addressed byte or halfword down to bit 0. It then extends the value with the sign bit or with zeros into the destination register value.

The unit also checks the access for natural alignment. It reports a misaligned load and a misaligned store on separate outputs, together with the matching exception cause code. A misaligned store writes nothing.

Top module: `lsu_align_unit`

## Requirements
- R1: A valid, aligned store with size code 2'b00 (byte) drives byte_en_o = 4'b0001 shifted left by addr_lo_i.
- R2: A valid, aligned store with size code 2'b01 (halfword) drives byte_en_o = 4'b0011 at offset 0 and 4'b1100 at offset 2.
- R3: A valid, aligned store with size code 2'b10 or 2'b11 (word) drives byte_en_o = 4'b1111.
- R4: store_word_o is the following value, whether or not the access is valid:
  - for a byte, the low byte of store_data_i repeated in all four lanes;
  - for a halfword, the low halfword repeated twice;
  - for a word, store_data_i unchanged.
- R5: byte_en_o is 4'b0000 whenever valid_i is low or is_store_i is low (a load).
- R6: For a byte load, load_result_o is bits [7:0] of load_word_i shifted right by 8*addr_lo_i. The value is zero-extended when unsigned_i is 1 and sign-extended from bit 7 otherwise.
- R7: For a halfword load, load_result_o is bits [15:0] of load_word_i shifted right by 8*addr_lo_i. The value is zero-extended when unsigned_i is 1 and sign-extended from bit 15 otherwise.
- R8: For a word load, load_result_o is load_word_i shifted right by 8*addr_lo_i, with zeros filled in from the top. At offset 0 this is load_word_i unchanged.
- R9: An access is misaligned in these cases only:
  - a halfword with addr_lo_i[0] set;
  - a word with addr_lo_i not equal to 0.
  A byte access is never misaligned.
- R10: The misalignment flags depend on valid_i and is_store_i:
  - ld_misalign_o is raised only for a valid misaligned load, and st_misalign_o only for a valid misaligned store.
  - fault_cause_o is 4 for a load, 6 for a store, and 0 when no flag is raised.
- R11: A misaligned store drives byte_en_o = 4'b0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| valid_i | input | 1 | Memory access is valid this cycle |
| is_store_i | input | 1 | 1 = store, 0 = load |
| size_i | input | 2 | 00 byte, 01 halfword, 1x word |
| unsigned_i | input | 1 | Zero-extend load result |
| addr_lo_i | input | 2 | Byte offset within the word |
| store_data_i | input | 32 | Source register value for stores |
| load_word_i | input | 32 | Raw word read from memory |
| byte_en_o | output | 4 | Per-lane write enables |
| store_word_o | output | 32 | Lane-replicated write data |
| load_result_o | output | 32 | Extended load value |
| ld_misalign_o | output | 1 | Misaligned load flag |
| st_misalign_o | output | 1 | Misaligned store flag |
| fault_cause_o | output | 4 | Exception cause code (0, 4 or 6) |

## Verification
A directed sweep covers every combination of the following inputs:
- valid,
- direction,
- size code,
- signedness,
- offset.

The sweep runs with two fixed data words. One word has the top bit of every byte set and the other has it clear, so sign extension and zero extension give different results. Distinct byte values in each lane show whether the right lane was shifted down, and whether store data was replicated rather than shifted.

Random vectors then cover data patterns across all modes, including reserved size code 2'b11. Every vector checks the misaligned offsets against the mask, the flags and the cause code.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_WORD2 = 2'b11
  } acc_size_e;

  localparam logic [3:0] CAUSE_NONE   = 4'd0;
  localparam logic [3:0] CAUSE_LD_MIS = 4'd4;
  localparam logic [3:0] CAUSE_ST_MIS = 4'd6;
endpackage

// File: rtl/lsu_misalign_check.sv
module lsu_misalign_check
  import lsu_align_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  acc_size_e        size_i,
  input  logic [OFF_W-1:0] addr_lo_i,
  output logic             misaligned_o
);
  always_comb begin
    unique case (size_i)
      SZ_BYTE: misaligned_o = 1'b0;
      SZ_HALF: misaligned_o = addr_lo_i[0];
      default: misaligned_o = (addr_lo_i != '0);
    endcase
  end
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  acc_size_e         size_i,
  input  logic [OFF_W-1:0]  addr_lo_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              write_ok_i,
  output logic [LANES-1:0]  byte_en_o,
  output logic [DATA_W-1:0] wdata_o
);
  localparam logic [LANES-1:0] BYTE_MASK = LANES'(1);
  localparam logic [LANES-1:0] HALF_MASK = LANES'(3);

  logic [OFF_W-1:0] half_off;
  logic [LANES-1:0] mask_raw;

  assign half_off = {addr_lo_i[OFF_W-1:1], 1'b0};

  always_comb begin
    unique case (size_i)
      SZ_BYTE: mask_raw = BYTE_MASK << addr_lo_i;
      SZ_HALF: mask_raw = HALF_MASK << half_off;
      default: mask_raw = '1;
    endcase
  end

  assign byte_en_o = write_ok_i ? mask_raw : '0;

  // Replicate the narrow value into every lane
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_comb begin
      unique case (size_i)
        SZ_BYTE: wdata_o[8*k +: 8] = data_i[7:0];
        SZ_HALF: wdata_o[8*k +: 8] = data_i[8*(k%2) +: 8];
        default: wdata_o[8*k +: 8] = data_i[8*k +: 8];
      endcase
    end
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  acc_size_e         size_i,
  input  logic              unsigned_i,
  input  logic [OFF_W-1:0]  addr_lo_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] result_o
);
  logic [DATA_W-1:0] shifted;
  logic              sext_b;
  logic              sext_h;

  assign shifted = word_i >> {addr_lo_i, 3'b000};
  assign sext_b  = ~unsigned_i & shifted[7];
  assign sext_h  = ~unsigned_i & shifted[15];

  always_comb begin
    unique case (size_i)
      SZ_BYTE: result_o = {{(DATA_W-8){sext_b}}, shifted[7:0]};
      SZ_HALF: result_o = {{(DATA_W-16){sext_h}}, shifted[15:0]};
      default: result_o = shifted;
    endcase
  end
endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic              valid_i,
  input  logic              is_store_i,
  input  logic [1:0]        size_i,
  input  logic              unsigned_i,
  input  logic [OFF_W-1:0]  addr_lo_i,
  input  logic [DATA_W-1:0] store_data_i,
  input  logic [DATA_W-1:0] load_word_i,
  output logic [LANES-1:0]  byte_en_o,
  output logic [DATA_W-1:0] store_word_o,
  output logic [DATA_W-1:0] load_result_o,
  output logic              ld_misalign_o,
  output logic              st_misalign_o,
  output logic [3:0]        fault_cause_o
);
  acc_size_e size;
  logic      mis_raw;
  logic      write_ok;

  assign size = acc_size_e'(size_i);

  lsu_misalign_check #(.OFF_W(OFF_W)) u_mis (
    .size_i      (size),
    .addr_lo_i   (addr_lo_i),
    .misaligned_o(mis_raw)
  );

  assign ld_misalign_o = valid_i & ~is_store_i & mis_raw;
  assign st_misalign_o = valid_i &  is_store_i & mis_raw;
  assign write_ok      = valid_i &  is_store_i & ~mis_raw;

  always_comb begin
    if (st_misalign_o)      fault_cause_o = CAUSE_ST_MIS;
    else if (ld_misalign_o) fault_cause_o = CAUSE_LD_MIS;
    else                    fault_cause_o = CAUSE_NONE;
  end

  lsu_store_lane #(.DATA_W(DATA_W)) u_st (
    .size_i    (size),
    .addr_lo_i (addr_lo_i),
    .data_i    (store_data_i),
    .write_ok_i(write_ok),
    .byte_en_o (byte_en_o),
    .wdata_o   (store_word_o)
  );

  lsu_load_extract #(.DATA_W(DATA_W)) u_ld (
    .size_i    (size),
    .unsigned_i(unsigned_i),
    .addr_lo_i (addr_lo_i),
    .word_i    (load_word_i),
    .result_o  (load_result_o)
  );

  always_comb begin
    if (byte_en_o != '0) begin
      AST_BE_NEEDS_STORE: assert (valid_i && is_store_i) else $error("enable without store"); // R5
    end
    if (ld_misalign_o || st_misalign_o) begin
      AST_MIS_BLOCKS_BE: assert (byte_en_o == '0) else $error("enable on misaligned"); // R11
    end
    AST_FLAG_EXCL: assert (!(ld_misalign_o && st_misalign_o)) else $error("both flags"); // R10
    if (!valid_i) begin
      AST_IDLE_QUIET: assert (fault_cause_o == CAUSE_NONE && !ld_misalign_o && !st_misalign_o)
        else $error("flag while idle"); // R10
    end
    if (size == SZ_BYTE) begin
      AST_BYTE_NEVER_MIS: assert (!ld_misalign_o && !st_misalign_o) else $error("byte misaligned"); // R9
      if (valid_i && is_store_i) begin
        AST_BYTE_ONE_LANE: assert ($countones(byte_en_o) == 1) else $error("byte lanes"); // R1
      end
    end
    if (size == SZ_HALF && byte_en_o != '0) begin
      AST_HALF_TWO_LANES: assert ($countones(byte_en_o) == 2) else $error("half lanes"); // R2
    end
  end
endmodule

// File: tb/lsu_align_unit_test.sv
module lsu_align_unit_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0, is_store_i = 1'b0, unsigned_i = 1'b0;
  logic [1:0]  size_i = '0, addr_lo_i = '0;
  logic [31:0] store_data_i = '0, load_word_i = '0;
  logic [3:0]  byte_en_o;
  logic [31:0] store_word_o, load_result_o;
  logic        ld_misalign_o, st_misalign_o;
  logic [3:0]  fault_cause_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  lsu_align_unit uut (
    .valid_i(valid_i), .is_store_i(is_store_i), .size_i(size_i), .unsigned_i(unsigned_i),
    .addr_lo_i(addr_lo_i), .store_data_i(store_data_i), .load_word_i(load_word_i),
    .byte_en_o(byte_en_o), .store_word_o(store_word_o), .load_result_o(load_result_o),
    .ld_misalign_o(ld_misalign_o), .st_misalign_o(st_misalign_o), .fault_cause_o(fault_cause_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (v=%0b st=%0b sz=%0d u=%0b off=%0d)",
               tag, act, exp, valid_i, is_store_i, size_i, unsigned_i, addr_lo_i);
    end
  endtask

  // Behavioural reference, evaluated from the requirements
  task automatic check_all();
    int off = addr_lo_i;
    int sz  = size_i;
    bit mis;
    logic [3:0]  be;
    logic [31:0] wd, ld, sh;
    int cause;
    mis = (sz == 1 && off % 2 == 1) || (sz >= 2 && off != 0);
    if (valid_i && is_store_i && !mis)
      be = (sz == 0) ? 4'(1 << off) : (sz == 1) ? 4'(3 << off) : 4'hF;
    else
      be = 4'h0;
    if (sz == 0)      wd = {4{store_data_i[7:0]}};
    else if (sz == 1) wd = {2{store_data_i[15:0]}};
    else              wd = store_data_i;
    sh = load_word_i >> (8 * off);
    if (sz == 0)      ld = unsigned_i ? {24'h0, sh[7:0]}  : 32'($signed(sh[7:0]));
    else if (sz == 1) ld = unsigned_i ? {16'h0, sh[15:0]} : 32'($signed(sh[15:0]));
    else              ld = sh;
    cause = (valid_i && mis) ? (is_store_i ? 6 : 4) : 0;
    chk("R1 R2 R3 R5 R11 byte_en", {28'h0, byte_en_o}, {28'h0, be});
    chk("R4 store_word", store_word_o, wd);
    if (sz == 0)      chk("R6 byte load", load_result_o, ld);
    else if (sz == 1) chk("R7 half load", load_result_o, ld);
    else              chk("R8 word load", load_result_o, ld);
    chk("R9 R10 ld_misalign", {31'h0, ld_misalign_o}, {31'h0, valid_i && !is_store_i && mis});
    chk("R9 R10 st_misalign", {31'h0, st_misalign_o}, {31'h0, valid_i && is_store_i && mis});
    chk("R10 cause", {28'h0, fault_cause_o}, 32'(cause));
  endtask

  task automatic apply(input bit v, input bit st, input logic [1:0] sz, input bit u,
                       input logic [1:0] off, input logic [31:0] sd, input logic [31:0] lw);
    @(negedge clk);
    valid_i = v; is_store_i = st; size_i = sz; unsigned_i = u;
    addr_lo_i = off; store_data_i = sd; load_word_i = lw;
    @(posedge clk);
    #1 check_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check_all();  // idle state under reset
    rst_ni = 1'b1;
    // Directed sweep: high-bit-set and high-bit-clear lane patterns
    for (int d = 0; d < 2; d++) begin
      for (int v = 0; v < 2; v++)
        for (int st = 0; st < 2; st++)
          for (int sz = 0; sz < 4; sz++)
            for (int u = 0; u < 2; u++)
              for (int off = 0; off < 4; off++)
                apply(v[0], st[0], sz[1:0], u[0], off[1:0],
                      d == 0 ? 32'hA1B2C3D4 : 32'h12345678,
                      d == 0 ? 32'h8F9EADBC : 32'h1A2B3C4D);
    end
    // Random vectors
    for (int i = 0; i < 3000; i++)
      apply(1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom), 2'($urandom),
            $urandom, $urandom);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule